// File: doc/BRIEF.md
# Spread-Spectrum Burst Transmitter

This block is the sending side of a low-rate direct-sequence spread-spectrum link. A host processor hands it one byte at a time over a small parallel bus with a select strobe, a read/write select and an interrupt line. The byte lands in a one-deep holding register. The block serializes it most significant bit first and multiplies each bit by an internally produced 8-chip pseudo-noise word. The result leaves as a single chip stream at eight times the bit rate.

Each burst opens with a fixed 8-bit sync word so that a receiver can find the data timing. After the sync word, bytes follow back to back for as long as the host keeps the holding register filled. When the register is empty at the end of a byte, the burst ends and the line returns to 0. The interrupt tells the host that the holding register can take another byte. A status read reports whether the register is empty, whether a burst is in progress, and whether a byte was ever lost to an overfull write.

Top module: `dsss_burst_tx`

## Requirements
- R1: After reset, `chip_out` is 0, `tx_active` is 0 and `irq` is 1. A status read returns 8'h01.
- R2: A write (`ce`=1, `rw`=0) while no burst is active loads the byte. On the next clock edge `tx_active` rises and the burst starts with the sync word (default 8'hA5) ahead of that byte.
- R3: Every bit occupies PN_LEN chips, and every chip holds `chip_out` steady for CHIP_DIV clock cycles. Bits of each byte go out most significant first.
- R4: Chip k of a bit (k = 0 first) equals the bit XOR PN_WORD[PN_LEN-1-k], with default PN_WORD 8'b1110_0100. A 0 bit therefore sends the word as it is, and a 1 bit sends it inverted.
- R5: A byte written while a burst runs goes out right after the current byte, with no gap and no second sync word.
- R6: If the holding register is empty when a byte ends, `tx_active` and `chip_out` both drop to 0 on that chip boundary. The next write starts a new burst that again begins with the sync word.
- R7: `irq` is 1 exactly while the holding register is empty. It drops on the clock edge of an accepted write and rises again when the burst takes the byte.
- R8: A status read (`ce`=1, `rw`=1) updates `rdata` on that clock edge. Bit 0 is empty, bit 1 is busy (burst active) and bit 2 is overflow. All other bits are 0.
- R9: A write while the holding register is full is discarded, and the byte already held is sent unchanged. The write also sets the overflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Bus select strobe |
| rw | input | 1 | 1 = status read, 0 = byte write |
| wdata | input | DATA_W | Byte from host |
| rdata | output | DATA_W | Registered status word |
| irq | output | 1 | Holding register empty |
| chip_out | output | 1 | Spread chip stream |
| tx_active | output | 1 | Burst in progress |

## Verification
The bench sends a single byte and then a 256-byte burst that covers every byte value. It compares each chip period cycle by cycle against the XOR of bit and PN word. A design that drops or repeats the sync word, reverses bit or chip order, or slips a chip fails on the first such chip. During the sync word the bench writes into a full register. A design that overwrote the held byte would send the wrong payload, and a flag that was not sticky would show up in the final status read. The end-of-burst boundary is checked on the exact cycle: a design that ran one extra bit, or left the line high, would be caught there.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;
  typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
  localparam int STAT_EMPTY = 0;
  localparam int STAT_BUSY  = 1;
  localparam int STAT_OVF   = 2;
endpackage

// File: rtl/dsss_rate_gen.sv
module dsss_rate_gen #(
  parameter int CHIP_DIV = 4,
  parameter int PN_LEN   = 8,
  localparam int IW = (PN_LEN > 1) ? $clog2(PN_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          chip_en,
  output logic          bit_en,
  output logic [IW-1:0] chip_idx
);
  localparam logic [IW-1:0] LAST_CHIP = IW'(PN_LEN - 1);

  generate
    if (CHIP_DIV == 1) begin : g_nodiv
      assign chip_en = run;
    end else begin : g_div
      localparam int CW = $clog2(CHIP_DIV);
      localparam logic [CW-1:0] LAST_CYC = CW'(CHIP_DIV - 1);
      logic [CW-1:0] cyc_q;
      always_ff @(posedge clk) begin
        if (rst || !run)       cyc_q <= '0;
        else if (cyc_q == LAST_CYC) cyc_q <= '0;
        else                   cyc_q <= cyc_q + 1'b1;
      end
      assign chip_en = run && (cyc_q == LAST_CYC);
    end
  endgenerate

  assign bit_en = chip_en && (chip_idx == LAST_CHIP);

  always_ff @(posedge clk) begin
    if (rst || !run)  chip_idx <= '0;
    else if (chip_en) chip_idx <= (chip_idx == LAST_CHIP) ? '0 : chip_idx + 1'b1;
  end
endmodule

// File: rtl/dsss_host_if.sv
module dsss_host_if
  import dsss_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              rw,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              ovf_q
);
  logic wr, rd, accept, full_next;
  logic [DATA_W-1:0] status;

  assign wr        = ce && !rw;
  assign rd        = ce && rw;
  assign accept    = wr && (!hold_full || take);
  assign full_next = accept ? 1'b1 : (take ? 1'b0 : hold_full);

  always_comb begin
    status = '0;
    status[STAT_EMPTY] = !hold_full;
    status[STAT_BUSY]  = busy;
    status[STAT_OVF]   = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      ovf_q     <= 1'b0;
      irq       <= 1'b1;
      rdata     <= '0;
    end else begin
      hold_full <= full_next;
      irq       <= !full_next;
      if (accept)      hold_data <= wdata;
      if (wr && !accept) ovf_q   <= 1'b1;
      if (rd)          rdata     <= status;
    end
  end
endmodule

// File: rtl/dsss_framer.sv
module dsss_framer
  import dsss_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PN_LEN = 8,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 8'hA5,
  parameter logic [PN_LEN-1:0] PN_WORD    = 8'b1110_0100,
  localparam int IW = (PN_LEN > 1) ? $clog2(PN_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              bit_en,
  input  logic [IW-1:0]     chip_idx,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              chip_out,
  output logic              tx_active
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  tx_state_t         state;
  logic [DATA_W-1:0] sreg;
  logic [BW-1:0]     bit_idx;
  logic [IW-1:0]     next_chip;

  function automatic logic pn_at(input logic [IW-1:0] idx);
    return PN_WORD[PN_LEN-1-int'(idx)];
  endfunction

  assign next_chip = chip_idx + 1'b1;
  assign take = (state == TX_SEND) && bit_en && (bit_idx == LAST_BIT) && hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      sreg      <= '0;
      bit_idx   <= '0;
      chip_out  <= 1'b0;
      tx_active <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (hold_full) begin
            state     <= TX_SEND;
            sreg      <= TRAIN_WORD;
            bit_idx   <= '0;
            chip_out  <= TRAIN_WORD[DATA_W-1] ^ pn_at('0);
            tx_active <= 1'b1;
          end
        end
        TX_SEND: begin
          if (chip_en) begin
            if (!bit_en) begin
              chip_out <= sreg[DATA_W-1] ^ pn_at(next_chip);
            end else if (bit_idx != LAST_BIT) begin
              sreg     <= sreg << 1;
              bit_idx  <= bit_idx + 1'b1;
              chip_out <= sreg[DATA_W-2] ^ pn_at('0);
            end else if (hold_full) begin
              sreg     <= hold_data;
              bit_idx  <= '0;
              chip_out <= hold_data[DATA_W-1] ^ pn_at('0);
            end else begin
              state     <= TX_IDLE;
              chip_out  <= 1'b0;
              tx_active <= 1'b0;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsss_burst_tx.sv
module dsss_burst_tx #(
  parameter int DATA_W   = 8,
  parameter int PN_LEN   = 8,
  parameter int CHIP_DIV = 4,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 8'hA5,
  parameter logic [PN_LEN-1:0] PN_WORD    = 8'b1110_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              rw,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              chip_out,
  output logic              tx_active
);
  localparam int IW = (PN_LEN > 1) ? $clog2(PN_LEN) : 1;

  logic              chip_en, bit_en, take, hold_full, ovf_w;
  logic [IW-1:0]     chip_idx;
  logic [DATA_W-1:0] hold_data;

  dsss_host_if #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst(rst), .ce(ce), .rw(rw), .wdata(wdata),
    .busy(tx_active), .take(take), .hold_full(hold_full),
    .hold_data(hold_data), .rdata(rdata), .irq(irq), .ovf_q(ovf_w)
  );

  dsss_rate_gen #(.CHIP_DIV(CHIP_DIV), .PN_LEN(PN_LEN)) u_rate (
    .clk(clk), .rst(rst), .run(tx_active),
    .chip_en(chip_en), .bit_en(bit_en), .chip_idx(chip_idx)
  );

  dsss_framer #(
    .DATA_W(DATA_W), .PN_LEN(PN_LEN),
    .TRAIN_WORD(TRAIN_WORD), .PN_WORD(PN_WORD)
  ) u_frame (
    .clk(clk), .rst(rst), .chip_en(chip_en), .bit_en(bit_en),
    .chip_idx(chip_idx), .hold_full(hold_full), .hold_data(hold_data),
    .take(take), .chip_out(chip_out), .tx_active(tx_active)
  );
endmodule

// File: rtl/dsss_burst_tx_sva.sv
module dsss_burst_tx_sva #(
  parameter int DATA_W = 8,
  parameter int PN_LEN = 8,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 8'hA5,
  parameter logic [PN_LEN-1:0] PN_WORD    = 8'b1110_0100
) (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic rw,
  input logic irq,
  input logic chip_out,
  input logic tx_active,
  input logic ovf
);
  a_r6_idle_line_low: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> !chip_out);

  a_r2_burst_opens_with_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> (chip_out == (TRAIN_WORD[DATA_W-1] ^ PN_WORD[PN_LEN-1])));

  a_r2_start_has_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> !irq);

  a_r7_irq_drop_on_write: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(ce && !rw));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind dsss_burst_tx dsss_burst_tx_sva #(
  .DATA_W(DATA_W), .PN_LEN(PN_LEN), .TRAIN_WORD(TRAIN_WORD), .PN_WORD(PN_WORD)
) u_sva (
  .clk(clk), .rst(rst), .ce(ce), .rw(rw), .irq(irq),
  .chip_out(chip_out), .tx_active(tx_active), .ovf(ovf_w)
);

// File: tb/dsss_burst_tx_tb.sv
module dsss_burst_tx_tb;
  localparam int DW = 8;
  localparam int PL = 8;
  localparam int CD = 4;
  localparam logic [7:0] TRAIN = 8'hA5;
  localparam logic [7:0] PN    = 8'b1110_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, rw = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, chip_out, tx_active;

  int checks = 0;
  int errors = 0;
  logic [7:0] pay [256];
  int pay_n = 0;

  always #4 clk = ~clk;

  dsss_burst_tx #(.DATA_W(DW), .PN_LEN(PL), .CHIP_DIV(CD),
                  .TRAIN_WORD(TRAIN), .PN_WORD(PN)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .rw(rw), .wdata(wdata),
    .rdata(rdata), .irq(irq), .chip_out(chip_out), .tx_active(tx_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] v);
    ce = 1'b1; rw = 1'b0; wdata = v;
    @(posedge clk);
    @(negedge clk);
    ce = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] v);
    ce = 1'b1; rw = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ce = 1'b0; rw = 1'b0;
    v = rdata;
  endtask

  // Checks every chip of a burst made of the sync word and pay[0..pay_n-1].
  task automatic run_monitor();
    do @(negedge clk); while (!tx_active);
    for (int b = 0; b <= pay_n; b++) begin
      logic [7:0] by;
      by = (b == 0) ? TRAIN : pay[b-1];
      for (int i = 0; i < 8; i++) begin
        for (int k = 0; k < PL; k++) begin
          logic exp_c;
          logic bad;
          logic seen;
          exp_c = by[7-i] ^ PN[PL-1-k];
          bad = 1'b0;
          seen = 1'b0;
          for (int c = 0; c < CD; c++) begin
            if (chip_out !== exp_c || tx_active !== 1'b1) begin
              bad = 1'b1; seen = chip_out;
            end
            @(negedge clk);
          end
          // R2 sync word, R3 timing/order, R4 spreading, R5 contiguous bytes
          check(!bad, (b == 0) ? "R2 sync chip" : "R4/R3/R5 payload chip",
                seen, exp_c);
        end
      end
    end
    check(tx_active === 1'b0 && chip_out === 1'b0, "R6 burst end",
          {tx_active, chip_out}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(chip_out === 1'b0 && tx_active === 1'b0, "R1 idle outputs",
          {tx_active, chip_out}, 0);
    check(irq === 1'b1, "R1 irq after reset", irq, 1);
    bus_read(st);
    check(st === 8'h01, "R1/R8 reset status", st, 8'h01);

    // Single-byte burst with an overfull write during the sync word
    pay[0] = 8'h3C; pay_n = 1;
    fork
      run_monitor();
      begin
        bus_write(8'h3C);
        check(irq === 1'b0, "R7 irq drops on write", irq, 0);
        repeat (3) @(negedge clk);
        bus_read(st);
        check(st === 8'h02, "R8 status busy", st, 8'h02);
        bus_write(8'hFF);
        check(irq === 1'b0, "R9 irq unchanged by lost write", irq, 0);
        bus_read(st);
        check(st === 8'h06, "R9 overflow flag set", st, 8'h06);
      end
    join
    check(irq === 1'b1, "R7 irq high after take", irq, 1);
    bus_read(st);
    check(st === 8'h05, "R9 overflow sticky, R8 idle status", st, 8'h05);

    // Full sweep of byte values in one burst, refilled on interrupt
    for (int v = 0; v < 256; v++) pay[v] = 8'(v);
    pay_n = 256;
    fork
      run_monitor();
      begin
        for (int v = 0; v < 256; v++) begin
          while (!irq) @(negedge clk);
          bus_write(8'(v));
        end
      end
    join
    check(irq === 1'b1, "R7 irq high at end", irq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule